// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block makes the interlock and bypass decisions for a soft processor with three stages: fetch/decode (FD), a combined read/execute/memory stage (EX), and writeback (WB). Each cycle it compares the source registers of the instruction held in FD against the destination of the instruction in EX. It decides whether the consumer can take the in-flight result through a bypass path, or whether it must wait one cycle. It also steers the program counter when a branch resolves in EX. The datapath, register file and ALU sit outside. The datapath feeds in decoded register fields and the branch outcome, and it acts on the stall, bubble, PC-select and bypass-select outputs.

The block tracks the producer that occupies EX by itself, so the only per-instruction inputs are the FD fields. A load returns its data too late to be bypassed, so a dependent instruction waits one cycle instead of needing a load delay slot. `NUM_FWD` picks a build with two bypass paths or a cheaper build with one. In the one-path build only operand A can be bypassed, and any dependence on operand B costs a stall. `DELAY_SLOT` picks what happens to the instruction fetched behind a taken branch under predict-not-taken. Either it is discarded, or it runs as a delay slot.

Top module: `pipe3_hazard_ctrl`

## Requirements
- R1: `fwd_a` is registered and applies to the instruction now in EX. It reads 1 when that instruction used operand A on a register that the previous instruction writes, and that previous instruction was a non-load in EX while the consumer sat in FD.
- R2: With `NUM_FWD`=2, `fwd_b` is decided for operand B in the same way and independently of operand A, including both operands naming the same register. A non-load dependence never stalls in this build.
- R3: With `NUM_FWD`=1, `fwd_b` is never set. A non-load dependence on operand B stalls for one cycle, and this includes an instruction that reads the same just-written register on both operands. A dependence on operand A alone is bypassed.
- R4: When a load in EX writes a register that the FD instruction reads on either used operand, the block stalls for one cycle. After that stall no bypass is selected for the consumer.
- R5: No bypass and no stall arise from register 0, from a producer that does not write, from an operand flagged unused, from an invalid FD slot, or from an empty EX slot.
- R6: A stall shows `stall`=1, `ex_bubble`=1 and `pc_sel`=1 (hold) when no branch is taken in that cycle. The bubble leaves EX empty, so a stall never lasts two cycles in a row.
- R7: With `DELAY_SLOT`=0, a taken branch in EX gives `pc_sel`=2 (target), `ex_bubble`=1 and `stall`=0. The discarded instruction never acts as a producer later.
- R8: With `DELAY_SLOT`=1, a taken branch gives `pc_sel`=2 with no bubble when there is no hazard. The instruction behind the branch enters EX and counts as a producer.
- R9: With `DELAY_SLOT`=1, when a taken branch and a stall fall in the same cycle, the outputs are `pc_sel`=2, `stall`=1 and `ex_bubble`=1. The delay-slot instruction is held and issues in the next cycle.
- R10: `ex_br_taken` is ignored while EX holds a bubble or no instruction, and `pc_sel` then stays 0 (sequential) unless a stall holds it at 1.
- R11: While `rst_n` is low and after it is released, EX is empty and `stall`, `ex_bubble`, `fwd_a`, `fwd_b` and `pc_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_valid | input | 1 | FD holds a real instruction |
| fd_use_a | input | 1 | FD instruction reads operand A |
| fd_src_a | input | REG_AW | Operand A register number |
| fd_use_b | input | 1 | FD instruction reads operand B |
| fd_src_b | input | REG_AW | Operand B register number |
| fd_dst | input | REG_AW | FD destination register |
| fd_writes | input | 1 | FD instruction writes `fd_dst` |
| fd_is_load | input | 1 | FD instruction is a load |
| ex_br_taken | input | 1 | Branch in EX resolved taken |
| stall | output | 1 | Hold the PC and the FD register |
| ex_bubble | output | 1 | Load a bubble into EX at the next edge |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 hold, 2 branch target |
| fwd_a | output | 1 | EX operand A takes the in-flight result |
| fwd_b | output | 1 | EX operand B takes the in-flight result |

## Verification
The case that needs the most care is a taken branch and an operand-B interlock in the same cycle. This happens in the delay-slot, single-path build when the branch writes a link register that the delay-slot instruction reads on operand B. The bench sets this up by issuing a link-writing branch and then a slot instruction that reads that register on B, with `ex_br_taken` raised. It expects target, stall and bubble together, and in the next cycle it expects the held slot instruction to issue with no further stall. The discarding build is judged by a different overlap: the squash must prevail, and a later reader of the discarded destination must see no bypass.

// File: rtl/hz3_pkg.sv
package hz3_pkg;

   typedef enum logic [1:0] {
      PCS_SEQ    = 2'd0,
      PCS_HOLD   = 2'd1,
      PCS_TARGET = 2'd2
   } pcsel_e;

   typedef struct packed {
      logic   stall;
      logic   bubble;
      pcsel_e pc;
   } flow_t;

endpackage

// File: rtl/hz3_dep_detect.sv
module hz3_dep_detect #(
   parameter int REG_AW  = 5,
   parameter int NUM_FWD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fd_valid,
   input  logic              fd_use_a,
   input  logic [REG_AW-1:0] fd_src_a,
   input  logic              fd_use_b,
   input  logic [REG_AW-1:0] fd_src_b,
   input  logic              ex_valid,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_writes,
   input  logic              ex_is_load,
   output logic              need_a,
   output logic              need_b,
   output logic              hazard
);

   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic producer_live;
   logic hit_a;
   logic hit_b;
   logic load_hit;

   assign producer_live = fd_valid & ex_valid & ex_writes;
   assign hit_a    = producer_live & fd_use_a & (fd_src_a != ZERO_REG) & (ex_dst == fd_src_a);
   assign hit_b    = producer_live & fd_use_b & (fd_src_b != ZERO_REG) & (ex_dst == fd_src_b);
   assign load_hit = ex_is_load & (hit_a | hit_b);

   generate
      if (NUM_FWD == 2) begin : g_two_path
         assign need_a = hit_a & ~ex_is_load;
         assign need_b = hit_b & ~ex_is_load;
         assign hazard = load_hit;
      end else begin : g_one_path
         assign need_a = hit_a & ~ex_is_load;
         assign need_b = 1'b0;
         assign hazard = load_hit | (hit_b & ~ex_is_load);
      end
   endgenerate

   AST_R0_NEVER_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
      (fd_src_a == ZERO_REG) |-> !need_a);  // R5

   AST_LOAD_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
      ex_is_load |-> !need_a && !need_b);  // R4

endmodule

// File: rtl/hz3_ex_track.sv
module hz3_ex_track #(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bubble,
   input  logic              fd_valid,
   input  logic [REG_AW-1:0] fd_dst,
   input  logic              fd_writes,
   input  logic              fd_is_load,
   input  logic              need_a,
   input  logic              need_b,
   output logic              ex_valid,
   output logic [REG_AW-1:0] ex_dst,
   output logic              ex_writes,
   output logic              ex_is_load,
   output logic              fwd_a,
   output logic              fwd_b
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_valid   <= 1'b0;
         ex_dst     <= '0;
         ex_writes  <= 1'b0;
         ex_is_load <= 1'b0;
         fwd_a      <= 1'b0;
         fwd_b      <= 1'b0;
      end else if (bubble) begin
         ex_valid   <= 1'b0;
         ex_dst     <= '0;
         ex_writes  <= 1'b0;
         ex_is_load <= 1'b0;
         fwd_a      <= 1'b0;
         fwd_b      <= 1'b0;
      end else begin
         ex_valid   <= fd_valid;
         ex_dst     <= fd_dst;
         ex_writes  <= fd_valid & fd_writes;
         ex_is_load <= fd_valid & fd_is_load;
         fwd_a      <= need_a;
         fwd_b      <= need_b;
      end
   end

   AST_BUBBLE_EMPTIES_EX: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> !ex_valid && !fwd_a && !fwd_b);  // R6

   AST_BYPASS_HAS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a || fwd_b) |-> $past(ex_writes && !ex_is_load));  // R1

endmodule

// File: rtl/hz3_flow_ctrl.sv
module hz3_flow_ctrl
   import hz3_pkg::*;
#(
   parameter bit DELAY_SLOT = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hazard,
   input  logic  ex_valid,
   input  logic  ex_br_taken,
   output flow_t flow
);

   logic taken;
   assign taken = ex_valid & ex_br_taken;

   generate
      if (DELAY_SLOT) begin : g_slot
         always_comb begin
            flow.stall  = hazard;
            flow.bubble = hazard;
            if (taken)       flow.pc = PCS_TARGET;
            else if (hazard) flow.pc = PCS_HOLD;
            else             flow.pc = PCS_SEQ;
         end

         AST_SLOT_PROCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
            (flow.pc == PCS_TARGET && !hazard) |-> !flow.bubble);  // R8
      end else begin : g_squash
         always_comb begin
            flow.stall  = hazard & ~taken;
            flow.bubble = hazard | taken;
            if (taken)       flow.pc = PCS_TARGET;
            else if (hazard) flow.pc = PCS_HOLD;
            else             flow.pc = PCS_SEQ;
         end

         AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (flow.pc == PCS_TARGET) |-> flow.bubble && !flow.stall);  // R7
      end
   endgenerate

endmodule

// File: rtl/pipe3_hazard_ctrl.sv
module pipe3_hazard_ctrl
   import hz3_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter int NUM_FWD    = 2,
   parameter bit DELAY_SLOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fd_valid,
   input  logic              fd_use_a,
   input  logic [REG_AW-1:0] fd_src_a,
   input  logic              fd_use_b,
   input  logic [REG_AW-1:0] fd_src_b,
   input  logic [REG_AW-1:0] fd_dst,
   input  logic              fd_writes,
   input  logic              fd_is_load,
   input  logic              ex_br_taken,
   output logic              stall,
   output logic              ex_bubble,
   output logic [1:0]        pc_sel,
   output logic              fwd_a,
   output logic              fwd_b
);

   localparam int PCS_W = $bits(pcsel_e);

   generate
      if (NUM_FWD != 1 && NUM_FWD != 2) begin : g_bad_fwd
         $error("NUM_FWD must be 1 or 2");
      end
      if (REG_AW < 1) begin : g_bad_aw
         $error("REG_AW must be at least 1");
      end
      if (PCS_W != 2) begin : g_bad_pcs
         $error("pc select encoding must be two bits");
      end
   endgenerate

   logic              ex_valid;
   logic [REG_AW-1:0] ex_dst;
   logic              ex_writes;
   logic              ex_is_load;
   logic              need_a;
   logic              need_b;
   logic              hazard;
   flow_t             flow;

   hz3_dep_detect #(.REG_AW(REG_AW), .NUM_FWD(NUM_FWD)) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .fd_valid   (fd_valid),
      .fd_use_a   (fd_use_a),
      .fd_src_a   (fd_src_a),
      .fd_use_b   (fd_use_b),
      .fd_src_b   (fd_src_b),
      .ex_valid   (ex_valid),
      .ex_dst     (ex_dst),
      .ex_writes  (ex_writes),
      .ex_is_load (ex_is_load),
      .need_a     (need_a),
      .need_b     (need_b),
      .hazard     (hazard)
   );

   hz3_flow_ctrl #(.DELAY_SLOT(DELAY_SLOT)) u_flow (
      .clk         (clk),
      .rst_n       (rst_n),
      .hazard      (hazard),
      .ex_valid    (ex_valid),
      .ex_br_taken (ex_br_taken),
      .flow        (flow)
   );

   hz3_ex_track #(.REG_AW(REG_AW)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .bubble     (flow.bubble),
      .fd_valid   (fd_valid),
      .fd_dst     (fd_dst),
      .fd_writes  (fd_writes),
      .fd_is_load (fd_is_load),
      .need_a     (need_a),
      .need_b     (need_b),
      .ex_valid   (ex_valid),
      .ex_dst     (ex_dst),
      .ex_writes  (ex_writes),
      .ex_is_load (ex_is_load),
      .fwd_a      (fwd_a),
      .fwd_b      (fwd_b)
   );

   assign stall     = flow.stall;
   assign ex_bubble = flow.bubble;
   assign pc_sel    = flow.pc;

   AST_STALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);  // R6

   AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && pc_sel != PCS_TARGET) |-> pc_sel == PCS_HOLD && ex_bubble);  // R6

   AST_EMPTY_EX_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_valid |-> pc_sel != PCS_TARGET);  // R10

   generate
      if (NUM_FWD == 1) begin : g_one_chk
         AST_ONE_PATH_NO_B: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ex_valid && ex_writes) |-> !fwd_b);  // R3
      end
   endgenerate

endmodule

// File: tb/pipe3_hazard_ctrl_tb.sv
`timescale 1ns/100ps
module pipe3_hazard_ctrl_tb;

   localparam int AW = 5;
   localparam int NV = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          fd_valid, fd_use_a, fd_use_b, fd_writes, fd_is_load, ex_br_taken;
   logic [AW-1:0] fd_src_a, fd_src_b, fd_dst;

   logic       a_stall, a_bub, a_fa, a_fb;
   logic [1:0] a_pc;
   logic       b_stall, b_bub, b_fa, b_fb;
   logic [1:0] b_pc;

   int checks = 0;
   int errors = 0;

   pipe3_hazard_ctrl #(.REG_AW(AW), .NUM_FWD(2), .DELAY_SLOT(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .fd_valid(fd_valid), .fd_use_a(fd_use_a),
      .fd_src_a(fd_src_a), .fd_use_b(fd_use_b), .fd_src_b(fd_src_b),
      .fd_dst(fd_dst), .fd_writes(fd_writes), .fd_is_load(fd_is_load),
      .ex_br_taken(ex_br_taken), .stall(a_stall), .ex_bubble(a_bub),
      .pc_sel(a_pc), .fwd_a(a_fa), .fwd_b(a_fb));

   pipe3_hazard_ctrl #(.REG_AW(AW), .NUM_FWD(1), .DELAY_SLOT(1'b1)) u_alt (
      .clk(clk), .rst_n(rst_n), .fd_valid(fd_valid), .fd_use_a(fd_use_a),
      .fd_src_a(fd_src_a), .fd_use_b(fd_use_b), .fd_src_b(fd_src_b),
      .fd_dst(fd_dst), .fd_writes(fd_writes), .fd_is_load(fd_is_load),
      .ex_br_taken(ex_br_taken), .stall(b_stall), .ex_bubble(b_bub),
      .pc_sel(b_pc), .fwd_a(b_fa), .fwd_b(b_fb));

   // input fields: valid, use_a, src_a, use_b, src_b, dst, writes, load, taken (21 bits)
   // expected: stall, bubble, pc_sel, fwd_a, fwd_b (6 bits)
   localparam logic [26:0] VEC [NV] = '{
      {1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd3, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 0 R1
      {1'b1,1'b1,5'd3, 1'b1,5'd3, 5'd4, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b1,1'b1}, // 1 R2
      {1'b1,1'b1,5'd6, 1'b1,5'd4, 5'd5, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b1}, // 2 R2
      {1'b1,1'b1,5'd5, 1'b0,5'd0, 5'd7, 1'b1,1'b1,1'b0, 1'b0,1'b0,2'd0,1'b1,1'b0}, // 3 R1
      {1'b1,1'b1,5'd7, 1'b1,5'd1, 5'd8, 1'b1,1'b0,1'b0, 1'b1,1'b1,2'd1,1'b0,1'b0}, // 4 R4
      {1'b1,1'b1,5'd7, 1'b1,5'd1, 5'd8, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 5 R6
      {1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd0, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 6 R5
      {1'b1,1'b1,5'd0, 1'b1,5'd0, 5'd9, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 7 R5
      {1'b1,1'b1,5'd9, 1'b1,5'd9, 5'd9, 1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b1,1'b1}, // 8 R2
      {1'b1,1'b1,5'd9, 1'b1,5'd9, 5'd10,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 9 R5
      {1'b1,1'b0,5'd10,1'b0,5'd10,5'd11,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 10 R5
      {1'b1,1'b1,5'd11,1'b1,5'd1, 5'd0, 1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b1,1'b0}, // 11 R1
      {1'b1,1'b1,5'd1, 1'b1,5'd2, 5'd12,1'b1,1'b0,1'b1, 1'b0,1'b1,2'd2,1'b0,1'b0}, // 12 R7
      {1'b1,1'b1,5'd12,1'b1,5'd12,5'd13,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 13 R7
      {1'b1,1'b1,5'd13,1'b0,5'd0, 5'd14,1'b1,1'b1,1'b0, 1'b0,1'b0,2'd0,1'b1,1'b0}, // 14 R1
      {1'b1,1'b0,5'd0, 1'b1,5'd14,5'd15,1'b1,1'b0,1'b0, 1'b1,1'b1,2'd1,1'b0,1'b0}, // 15 R4
      {1'b1,1'b0,5'd0, 1'b1,5'd14,5'd15,1'b1,1'b0,1'b1, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 16 R10
      {1'b0,1'b1,5'd15,1'b1,5'd15,5'd16,1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}, // 17 R5
      {1'b1,1'b1,5'd16,1'b1,5'd16,5'd1, 1'b1,1'b0,1'b0, 1'b0,1'b0,2'd0,1'b0,1'b0}  // 18 R5
   };

   function automatic string vreq(int i);
      case (i)
         0, 3, 11, 14: return "R1";
         1, 2, 8:      return "R2";
         4, 15:        return "R4";
         5:            return "R6";
         12, 13:       return "R7";
         16:           return "R10";
         default:      return "R5";
      endcase
   endfunction

   task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic drive(logic [20:0] v);
      {fd_valid, fd_use_a, fd_src_a, fd_use_b, fd_src_b,
       fd_dst, fd_writes, fd_is_load, ex_br_taken} = v;
   endtask

   // one pipeline cycle: combinational outputs before the edge, bypass selects after it
   task automatic step(bit alt, logic [20:0] v, logic [5:0] exp, string req);
      @(negedge clk);
      drive(v);
      #1;
      if (alt) check(req, "alt stall/bubble/pc", {b_stall, b_bub, b_pc}, exp[5:2]);
      else     check(req, "main stall/bubble/pc", {a_stall, a_bub, a_pc}, exp[5:2]);
      @(posedge clk);
      #1;
      if (alt) check(req, "alt fwd", {2'b00, b_fa, b_fb}, {2'b00, exp[1:0]});
      else     check(req, "main fwd", {2'b00, a_fa, a_fb}, {2'b00, exp[1:0]});
   endtask

   localparam logic [20:0] NOP = '0;

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R11: reset holds everything at zero even with matching inputs and a taken flag
      drive({1'b1,1'b1,5'd3,1'b1,5'd3,5'd3,1'b1,1'b1,1'b1});
      repeat (3) @(posedge clk);
      #1;
      check("R11", "main outputs in reset", {a_stall, a_bub, a_pc}, 4'b0000);
      check("R11", "main fwd in reset", {2'b00, a_fa, a_fb}, 4'b0000);
      check("R11", "alt outputs in reset", {b_stall, b_bub, b_pc}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11", "main outputs after release", {a_stall, a_bub, a_pc}, 4'b0000);
      step(1'b0, NOP, 6'b000000, "R11");

      // table walk, two-path build without delay slot
      for (int i = 0; i < NV; i++) begin
         step(1'b0, VEC[i][26:6], VEC[i][5:0], vreq(i));
      end

      // R11: an asynchronous reset clears a pending bypass
      step(1'b0, {1'b1,1'b1,5'd0,1'b0,5'd0,5'd20,1'b1,1'b0,1'b0}, 6'b000000, "R11");
      @(negedge clk);
      drive({1'b1,1'b1,5'd20,1'b1,5'd20,5'd21,1'b1,1'b0,1'b0});
      rst_n = 1'b0;
      #1;
      check("R11", "fwd cleared by reset", {2'b00, a_fa, a_fb}, 4'b0000);
      @(posedge clk);
      #1;
      check("R11", "fwd stays clear in reset", {2'b00, a_fa, a_fb}, 4'b0000);
      @(negedge clk);
      drive(NOP);
      rst_n = 1'b1;

      // single-path build with delay slot
      step(1'b1, {1'b1,1'b1,5'd1,1'b1,5'd2,5'd3,1'b1,1'b0,1'b0}, 6'b000000, "R3");
      step(1'b1, {1'b1,1'b1,5'd3,1'b1,5'd3,5'd4,1'b1,1'b0,1'b0}, 6'b110100, "R3");
      step(1'b1, {1'b1,1'b1,5'd3,1'b1,5'd3,5'd4,1'b1,1'b0,1'b0}, 6'b000000, "R3");
      step(1'b1, {1'b1,1'b1,5'd4,1'b1,5'd6,5'd5,1'b1,1'b0,1'b0}, 6'b000010, "R3");
      step(1'b1, {1'b1,1'b1,5'd7,1'b1,5'd5,5'd6,1'b1,1'b0,1'b0}, 6'b110100, "R3");
      step(1'b1, {1'b1,1'b1,5'd7,1'b1,5'd5,5'd6,1'b1,1'b0,1'b0}, 6'b000000, "R6");
      step(1'b1, {1'b1,1'b0,5'd0,1'b0,5'd0,5'd31,1'b1,1'b0,1'b0}, 6'b000000, "R8");
      step(1'b1, {1'b1,1'b1,5'd31,1'b0,5'd0,5'd8,1'b1,1'b0,1'b1}, 6'b001010, "R8");
      step(1'b1, {1'b1,1'b0,5'd0,1'b1,5'd8,5'd9,1'b1,1'b0,1'b0}, 6'b110100, "R8");
      step(1'b1, {1'b1,1'b0,5'd0,1'b1,5'd8,5'd9,1'b1,1'b0,1'b0}, 6'b000000, "R8");
      step(1'b1, {1'b1,1'b0,5'd0,1'b0,5'd0,5'd31,1'b1,1'b0,1'b0}, 6'b000000, "R9");
      step(1'b1, {1'b1,1'b0,5'd0,1'b1,5'd31,5'd10,1'b1,1'b0,1'b1}, 6'b111000, "R9");
      step(1'b1, {1'b1,1'b0,5'd0,1'b1,5'd31,5'd10,1'b1,1'b0,1'b0}, 6'b000000, "R9");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule